// File: doc/BRIEF.md
# Byte-Serial Register-File Memory Mover

This block carries out the data movement of block load and block store instructions. It moves a run of bytes between a register file of 32-bit registers and a byte-addressed data memory. The caller gives a first register, a first byte lane inside that register, a byte count, a memory byte address and a direction. The block then steps through memory one byte per cycle. On the register side it walks the lanes in little-endian order, so the walk moves into the next register after lane 3.

Before any byte moves, the request is checked against three fault rules. The first is a span that runs past the end of the register file. The second is an access to the lowest memory word while a null guard is on. The third is an access reaching into the instruction space above a programmable base while standalone checking is on. A faulting request completes at once, reports a cause code and changes nothing. The register file sits inside the block. It has a word-wide port for the rest of the pipeline, and the mover uses a byte-lane write path into it. The memory is external and is reached through a synchronous single-byte port whose read data is valid one cycle after the request.

Top module: `regmem_mover`

## Requirements
- R1: A legal request with count N>0 makes exactly N memory accesses, one per cycle on consecutive cycles. The first uses the start address and each later one uses the previous address plus one.
- R2: Byte k of a transfer (k counting from 0) uses register (4*start_reg + start_lane + k) div 4 and lane (4*start_reg + start_lane + k) mod 4. After lane 3 the walk wraps to lane 0 of the next register.
- R3: A store (dir_store=1) writes bits [8n+7:8n] of the selected register to memory for lane n.
- R4: A load (dir_store=0) writes the memory byte into bits [8n+7:8n] of the selected register for lane n and leaves every other bit of the register file unchanged.
- R5: A request with 4*start_reg + start_lane + byte_count > 128 faults with fault_code 3. A request whose sum equals 128 is legal.
- R6: With null_guard_en=1, a start address below 4 faults with fault_code 1. With null_guard_en=0 such an address is legal.
- R7: With standalone_en=1, a request faults with fault_code 2 when start_addr >= ispace_base or start_addr + byte_count > ispace_base. A request ending exactly at the base is legal.
- R8: The fault causes are ranked null guard (1), then instruction space (2), then range (3). A faulting request makes no memory access, changes no register, never raises busy, and pulses done with its fault_code in the cycle after start.
- R9: A legal transfer of N>0 bytes holds busy high for N+2 cycles starting the cycle after start. done is then high for exactly one cycle with fault_code 0. busy and done are never high together.
- R10: A count of zero with no fault pulses done in the cycle after start, with no memory access and no busy.
- R11: A start pulse that arrives while busy is high is ignored and does not change the running transfer.
- R12: After reset busy, done, mem_req and fault_code are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| dir_store | input | 1 | 1 = register to memory, 0 = memory to register |
| start_reg | input | 5 | First register number |
| start_lane | input | 2 | First byte lane inside the first register |
| byte_count | input | 8 | Number of bytes to move |
| start_addr | input | 16 | First memory byte address |
| null_guard_en | input | 1 | Enables the low-address guard |
| standalone_en | input | 1 | Enables the instruction-space check |
| ispace_base | input | 16 | Lowest address of the instruction space |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | Cause reported with done: 0 none, 1 null, 2 instruction space, 3 range |
| mem_req | output | 1 | Memory byte access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read request |
| host_we | input | 1 | Word write into the register file |
| host_idx | input | 5 | Register written by host_we |
| host_wdata | input | 32 | Word written by host_we |
| host_rd_idx | input | 5 | Register shown on host_rdata |
| host_rdata | output | 32 | Combinational read of a register |

## Verification
The bench builds the block with its defaults: 32 registers, an 8-bit count, a 16-bit address and two cycles of tail latency. With these values the 128-byte range limit can be reached from the last register, and every lane wrap across all 32 registers is possible. The bench drives ispace_base at 0x300 and, in one case, at 1. That puts the instruction-space boundary and the ranking of the null and instruction-space faults inside a 1 KiB memory model. Counts up to 12 make each random transfer cross at least one register boundary from most start lanes.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
    localparam int unsigned LANES   = 4;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned WORD_W  = LANES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } mover_state_e;

    // Encodings are visible at the fault_code port.
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_NULL  = 2'd1,
        FLT_RSVD  = 2'd2,
        FLT_RANGE = 2'd3
    } fault_e;
endpackage

// File: rtl/regmem_regfile.sv
module regmem_regfile
    import regmem_pkg::*;
#(
    parameter int unsigned NREGS = 32,
    localparam int unsigned REG_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [REG_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              lane_we,
    input  logic [REG_W-1:0]  lane_idx,
    input  logic [1:0]        lane_sel,
    input  logic [LANE_W-1:0] lane_byte,
    input  logic [REG_W-1:0]  rd_idx_a,
    output logic [WORD_W-1:0] rd_data_a,
    input  logic [REG_W-1:0]  rd_idx_b,
    output logic [WORD_W-1:0] rd_data_b
);
    logic [NREGS*WORD_W-1:0] flat_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [WORD_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (host_we && host_idx == REG_W'(g))
                word_d = host_wdata;
            if (lane_we && lane_idx == REG_W'(g))
                word_d[{lane_sel, 3'b000} +: LANE_W] = lane_byte;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign flat_q[g*WORD_W +: WORD_W] = word_q;
    end

    assign rd_data_a = flat_q[rd_idx_a*WORD_W +: WORD_W];
    assign rd_data_b = flat_q[rd_idx_b*WORD_W +: WORD_W];

    // R4: a lane write touches only the addressed lane of the addressed register
    a_r4_lane_only: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we && !host_we && rd_idx_b == lane_idx
        |=> (rd_data_b & ~(32'hFF << {$past(lane_sel), 3'b000}))
            == ($past(rd_data_b) & ~(32'hFF << {$past(lane_sel), 3'b000}))
            || rd_idx_b != $past(rd_idx_b));
endmodule

// File: rtl/regmem_fault_check.sv
module regmem_fault_check
    import regmem_pkg::*;
#(
    parameter int unsigned NREGS       = 32,
    parameter int unsigned COUNT_W     = 8,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned GUARD_LIMIT = 4,
    localparam int unsigned REG_W  = $clog2(NREGS),
    localparam int unsigned SPAN_W = ((COUNT_W > REG_W + 2) ? COUNT_W : REG_W + 2) + 1,
    localparam int unsigned LIMIT  = NREGS * LANES
) (
    input  logic [REG_W-1:0]   start_reg,
    input  logic [1:0]         start_lane,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               null_guard_en,
    input  logic               standalone_en,
    input  logic [ADDR_W-1:0]  ispace_base,
    output fault_e             fault
);
    logic [SPAN_W-1:0] span_end;
    logic [ADDR_W:0]   addr_end;
    logic              hit_null, hit_rsvd, hit_range;

    assign span_end  = SPAN_W'({start_reg, start_lane}) + SPAN_W'(byte_count);
    assign addr_end  = {1'b0, start_addr} + (ADDR_W+1)'(byte_count);
    assign hit_null  = null_guard_en && (start_addr < ADDR_W'(GUARD_LIMIT));
    assign hit_rsvd  = standalone_en &&
                       ((start_addr >= ispace_base) || (addr_end > {1'b0, ispace_base}));
    assign hit_range = span_end > SPAN_W'(LIMIT);

    always_comb begin
        fault = FLT_NONE;
        if (hit_null)       fault = FLT_NULL;
        else if (hit_rsvd)  fault = FLT_RSVD;
        else if (hit_range) fault = FLT_RANGE;
    end
endmodule

// File: rtl/regmem_seq.sv
module regmem_seq
    import regmem_pkg::*;
#(
    parameter int unsigned NREGS     = 32,
    parameter int unsigned COUNT_W   = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned EXTRA_LAT = 2,
    localparam int unsigned REG_W  = $clog2(NREGS),
    localparam int unsigned TAIL_W = (EXTRA_LAT < 2) ? 1 : $clog2(EXTRA_LAT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir_store,
    input  logic [REG_W-1:0]   start_reg,
    input  logic [1:0]         start_lane,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic [ADDR_W-1:0]  start_addr,
    input  fault_e             fault_in,
    input  logic [WORD_W-1:0]  rf_rd_data,
    output logic [REG_W-1:0]   rf_rd_idx,
    output logic               lane_we,
    output logic [REG_W-1:0]   lane_idx,
    output logic [1:0]         lane_sel,
    output logic [LANE_W-1:0]  lane_byte,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LANE_W-1:0]  mem_wdata,
    input  logic [LANE_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output fault_e             fault_out
);
    typedef struct packed {
        mover_state_e       st;
        logic               store;
        logic [REG_W-1:0]   rnum;
        logic [1:0]         lane;
        logic [ADDR_W-1:0]  addr;
        logic [COUNT_W-1:0] left;
        logic [TAIL_W-1:0]  tail;
        logic               pend_v;
        logic [REG_W-1:0]   pend_reg;
        logic [1:0]         pend_lane;
        logic               done;
        fault_e             flt;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.flt    = FLT_NONE;
        d.pend_v = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.store = dir_store;
                    if (fault_in != FLT_NONE || byte_count == '0) begin
                        d.done = 1'b1;
                        d.flt  = fault_in;
                    end else begin
                        d.st   = ST_XFER;
                        d.rnum = start_reg;
                        d.lane = start_lane;
                        d.addr = start_addr;
                        d.left = byte_count;
                    end
                end
            end
            ST_XFER: begin
                d.pend_v    = !q.store;
                d.pend_reg  = q.rnum;
                d.pend_lane = q.lane;
                d.addr      = q.addr + ADDR_W'(1);
                d.lane      = q.lane + 2'd1;
                if (q.lane == 2'd3)
                    d.rnum = q.rnum + REG_W'(1);
                d.left = q.left - COUNT_W'(1);
                if (q.left == COUNT_W'(1)) begin
                    d.st   = ST_TAIL;
                    d.tail = TAIL_W'(EXTRA_LAT - 1);
                end
            end
            ST_TAIL: begin
                if (q.tail == '0) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.tail = q.tail - TAIL_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, flt: FLT_NONE, default: '0};
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign fault_out = q.flt;
    assign mem_req   = (q.st == ST_XFER);
    assign mem_we    = q.store;
    assign mem_addr  = q.addr;
    assign rf_rd_idx = q.rnum;
    assign mem_wdata = rf_rd_data[{q.lane, 3'b000} +: LANE_W];
    assign lane_we   = q.pend_v;
    assign lane_idx  = q.pend_reg;
    assign lane_sel  = q.pend_lane;
    assign lane_byte = mem_rdata;

    a_r9_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r1_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && q.left > COUNT_W'(1) |=> mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1));
    a_r2_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && q.lane == 2'd3 && q.left > COUNT_W'(1)
        |=> q.lane == 2'd0 && rf_rd_idx == $past(rf_rd_idx) + REG_W'(1));
    a_r8_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && fault_in != FLT_NONE |=> done && !busy && !mem_req && fault_out != FLT_NONE);
    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && byte_count == '0 |=> done && !busy && !mem_req);
endmodule

// File: rtl/regmem_mover.sv
module regmem_mover
    import regmem_pkg::*;
#(
    parameter int unsigned NREGS     = 32,
    parameter int unsigned COUNT_W   = 8,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned EXTRA_LAT = 2,
    localparam int unsigned REG_W    = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               dir_store,
    input  logic [REG_W-1:0]   start_reg,
    input  logic [1:0]         start_lane,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               null_guard_en,
    input  logic               standalone_en,
    input  logic [ADDR_W-1:0]  ispace_base,
    output logic               busy,
    output logic               done,
    output logic [1:0]         fault_code,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               host_we,
    input  logic [REG_W-1:0]   host_idx,
    input  logic [31:0]        host_wdata,
    input  logic [REG_W-1:0]   host_rd_idx,
    output logic [31:0]        host_rdata
);
    fault_e             chk_fault, seq_fault;
    logic [REG_W-1:0]   rf_rd_idx, lane_idx;
    logic [WORD_W-1:0]  rf_rd_data;
    logic               lane_we;
    logic [1:0]         lane_sel;
    logic [LANE_W-1:0]  lane_byte;

    regmem_fault_check #(
        .NREGS(NREGS), .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .GUARD_LIMIT(4)
    ) u_check (
        .start_reg(start_reg), .start_lane(start_lane), .byte_count(byte_count),
        .start_addr(start_addr), .null_guard_en(null_guard_en),
        .standalone_en(standalone_en), .ispace_base(ispace_base), .fault(chk_fault)
    );

    regmem_seq #(
        .NREGS(NREGS), .COUNT_W(COUNT_W), .ADDR_W(ADDR_W), .EXTRA_LAT(EXTRA_LAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_store(dir_store),
        .start_reg(start_reg), .start_lane(start_lane), .byte_count(byte_count),
        .start_addr(start_addr), .fault_in(chk_fault),
        .rf_rd_data(rf_rd_data), .rf_rd_idx(rf_rd_idx),
        .lane_we(lane_we), .lane_idx(lane_idx), .lane_sel(lane_sel), .lane_byte(lane_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault_out(seq_fault)
    );

    regmem_regfile #(.NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata),
        .lane_we(lane_we), .lane_idx(lane_idx), .lane_sel(lane_sel), .lane_byte(lane_byte),
        .rd_idx_a(rf_rd_idx), .rd_data_a(rf_rd_data),
        .rd_idx_b(host_rd_idx), .rd_data_b(host_rdata)
    );

    assign fault_code = seq_fault;
endmodule

// File: tb/regmem_mover_tb.sv
module regmem_mover_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS      = 32;
    localparam int MEMSZ      = 1024;
    localparam int BASE       = 'h300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_store = 1'b0;
    logic [4:0]  start_reg = '0;
    logic [1:0]  start_lane = '0;
    logic [7:0]  byte_count = '0;
    logic [15:0] start_addr = '0, ispace_base = BASE[15:0];
    logic        null_guard_en = 1'b0, standalone_en = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [1:0]  fault_code;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        host_we = 1'b0;
    logic [4:0]  host_idx = '0, host_rd_idx = '0;
    logic [31:0] host_wdata = '0, host_rdata;

    logic [7:0]  mem_model [MEMSZ];
    logic [7:0]  exp_mem   [MEMSZ];
    logic [31:0] exp_rf    [NREGS];
    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regmem_mover u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_store(dir_store),
        .start_reg(start_reg), .start_lane(start_lane), .byte_count(byte_count),
        .start_addr(start_addr), .null_guard_en(null_guard_en),
        .standalone_en(standalone_en), .ispace_base(ispace_base),
        .busy(busy), .done(done), .fault_code(fault_code),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_rd_idx(host_rd_idx), .host_rdata(host_rdata)
    );

    // synchronous byte memory, read data one cycle after the request
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem_model[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem_model[mem_addr[9:0]];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_fault(int r, int l, int n, int a, bit ng, bit sa, int base);
        if (ng && a < 4) return 1;
        if (sa && (a >= base || a + n > base)) return 2;
        if (r * 4 + l + n > 128) return 3;
        return 0;
    endfunction

    task automatic compare_state(input string req);
        int bad_mem = 0, bad_rf = 0, first_rf = -1;
        logic [31:0] got = '0, want = '0;
        for (int i = 0; i < MEMSZ; i++)
            if (mem_model[i] !== exp_mem[i]) bad_mem++;
        for (int i = 0; i < NREGS; i++) begin
            host_rd_idx = i[4:0];
            #1;
            if (host_rdata !== exp_rf[i]) begin
                bad_rf++;
                if (first_rf < 0) begin first_rf = i; got = host_rdata; want = exp_rf[i]; end
            end
        end
        check(bad_mem == 0, req, "memory bytes mismatching", bad_mem, 0);
        check(bad_rf == 0, req, $sformatf("register r%0d", first_rf), got, want);
    endtask

    // Called at a falling edge; returns at a falling edge.
    task automatic do_op(input string req, input int r, input int l, input int n,
                         input int a, input bit st, input bit ng, input bit sa,
                         input int base, input bit inject);
        int ef, busy_c, acc, cyc;
        bit addr_bad;
        ef = exp_fault(r, l, n, a, ng, sa, base);
        if (ef == 0) begin
            for (int i = 0; i < n; i++) begin
                int lin = r * 4 + l + i;
                int rr = lin / 4;
                int ll = lin % 4;
                if (st) exp_mem[a + i] = exp_rf[rr][8*ll +: 8];
                else    exp_rf[rr][8*ll +: 8] = exp_mem[a + i];
            end
        end
        start = 1'b1; dir_store = st; start_reg = r[4:0]; start_lane = l[1:0];
        byte_count = n[7:0]; start_addr = a[15:0]; null_guard_en = ng;
        standalone_en = sa; ispace_base = base[15:0];
        @(negedge clk);
        start = 1'b0;
        busy_c = 0; acc = 0; cyc = 0; addr_bad = 0;
        while (!done && cyc < 500) begin
            if (busy) busy_c++;
            if (mem_req) begin
                if (int'(mem_addr) != a + acc) addr_bad = 1;
                acc++;
            end
            if (inject && cyc == 1) begin
                // R11: second request while busy, different direction and address
                start = 1'b1; start_addr = 16'(a + 200); dir_store = !st;
            end else begin
                start = 1'b0; start_addr = a[15:0]; dir_store = st;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc < 500, req, "completion timeout", cyc, 0);
        check(int'(fault_code) == ef, req, "fault_code", fault_code, ef);
        check(acc == ((ef == 0) ? n : 0), {req, " R1"}, "access count", acc, (ef == 0) ? n : 0);
        check(!addr_bad, {req, " R1"}, "address sequence", addr_bad, 0);
        check(busy_c == ((ef == 0 && n > 0) ? n + 2 : 0), {req, " R9"}, "busy cycles",
              busy_c, (ef == 0 && n > 0) ? n + 2 : 0);
        @(negedge clk);
        check(done == 1'b0, {req, " R9"}, "done pulse width", done, 0);
        compare_state(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        for (int i = 0; i < MEMSZ; i++) begin
            mem_model[i] = 8'($urandom);
            exp_mem[i] = mem_model[i];
        end
        for (int i = 0; i < NREGS; i++) exp_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(busy == 1'b0 && done == 1'b0, "R12", "busy/done after reset", {busy, done}, 0);
        check(mem_req == 1'b0 && fault_code == 2'd0, "R12", "mem_req/fault after reset",
              {mem_req, fault_code}, 0);
        compare_state("R12");

        for (int i = 0; i < NREGS; i++) begin
            host_we = 1'b1; host_idx = i[4:0]; host_wdata = $urandom;
            exp_rf[i] = host_wdata;
            @(negedge clk);
        end
        host_we = 1'b0;

        // directed corner cases
        do_op("R2 R3 store across lane wrap", 2, 3, 6, 'h40, 1, 0, 0, BASE, 0);
        do_op("R2 R4 load across lane wrap", 5, 1, 7, 'h80, 0, 0, 0, BASE, 0);
        do_op("R5 span equal to 128", 31, 0, 4, 'h100, 0, 0, 0, BASE, 0);
        do_op("R5 span past 128", 31, 1, 4, 'h100, 0, 0, 0, BASE, 0);
        do_op("R6 null guard on", 4, 0, 2, 3, 1, 1, 0, BASE, 0);
        do_op("R6 null guard off", 4, 0, 3, 0, 1, 0, 0, BASE, 0);
        do_op("R7 end at base", 6, 2, 4, BASE - 4, 1, 0, 1, BASE, 0);
        do_op("R7 end past base", 6, 2, 5, BASE - 4, 0, 0, 1, BASE, 0);
        do_op("R7 start at base", 6, 2, 1, BASE, 1, 0, 1, BASE, 0);
        do_op("R8 null over rsvd", 31, 3, 8, 2, 1, 1, 1, 1, 0);
        do_op("R8 rsvd over range", 31, 3, 8, BASE, 0, 0, 1, BASE, 0);
        do_op("R10 zero count", 9, 2, 0, 'h20, 1, 0, 0, BASE, 0);
        do_op("R11 start while busy", 3, 0, 8, 'h180, 1, 0, 0, BASE, 1);
        do_op("R11 R4 start while busy load", 12, 3, 9, 'h1c0, 0, 0, 0, BASE, 1);

        // constrained random mix
        for (int k = 0; k < 80; k++) begin
            int r = $urandom_range(0, 31);
            int l = $urandom_range(0, 3);
            int n = $urandom_range(0, 12);
            int a = $urandom_range(0, 780);
            bit st = 1'($urandom);
            bit ng = ($urandom_range(0, 3) == 0);
            bit sa = ($urandom_range(0, 1) == 0);
            do_op(st ? "R3 random store" : "R4 random load", r, l, n, a, st, ng, sa, BASE, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule